// File: doc/BRIEF.md
# StreamID Span-Match Event Filter

This block decides, on every clock, which event counters of a translation-unit performance monitor may count the event seen in that cycle. Each counter owns two write-only settings. The first is an event selector, which holds an event code and a span flag. The second is a stream pattern, which holds a StreamID value. An incoming event arrives as a strobe vector indexed by event code, together with the StreamID of the transaction that raised it. The block compares that StreamID against each counter's pattern and drives a per-counter qualify vector. Whatever logic counts the events consumes this vector.

With the span flag clear, the StreamID must equal the stored pattern exactly. With the span flag set, the pattern itself encodes a wildcard width. The lowest zero bit of the stored value and every one below it are ignored, and all higher bits must match. A pattern of all ones therefore accepts every StreamID.

A configuration input selects shared filtering. In that mode the span flag and pattern of counter 0 filter every counter, and each counter still matches its own event code. Event code 0 stands for clock cycles. A counter set to code 0 qualifies on every clock, whatever the strobes or the StreamID.

Top module: `sid_span_filter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `qual` is all zeros after that edge. Reset leaves every counter with event code 0, span flag 1 and pattern all ones.
- R2: A counter whose event code is 0 asserts its `qual` bit on every cycle out of reset, regardless of `ev_hit` and `ev_sid`.
- R3: A counter with a nonzero event code c asserts `qual` only when `ev_hit[c]` is 1 and the filter matches. A code of `NUM_CODES` or above never qualifies.
- R4: With the span flag clear, the filter matches only when `ev_sid` equals the stored pattern in all 32 bits.
- R5: With the span flag set, let bit Y-1 be the lowest zero bit of the stored pattern. Bits 0 to Y-1 of the StreamID are ignored, and bits Y and up must equal the pattern. For example, pattern 0x42 accepts 0x42 and 0x43 only, and pattern 0x07 accepts 0x00 through 0x0F.
- R6: With the span flag set and a pattern of 0xFFFFFFFF, every StreamID matches.
- R7: When `glob_filt` is 1, counter 0's span flag and pattern filter all counters. Each counter keeps its own event code.
- R8: When `glob_filt` is 0, each counter is filtered by its own span flag and pattern.
- R9: A write sets the event selector of counter i at byte address 0x400+4i, taking the code from `wr_data[15:0]` and the span flag from `wr_data[29]`. A write sets the pattern of counter i at byte address 0xA00+4i. A write to any other address changes nothing.
- R10: `qual` is registered. It reflects the event, StreamID and settings present at the previous rising edge. A setting written at an edge first applies to the event presented at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_filt | input | 1 | 1: counter 0's filter applies to all counters |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 12 | Byte address of the setting written |
| wr_data | input | 32 | Write data |
| ev_hit | input | NUM_CODES (8) | One strobe per event code in this cycle |
| ev_sid | input | 32 | StreamID of this cycle's event |
| qual | output | NUM_CTR (4) | Per-counter count-qualify, registered |

## Verification
Every `qual` bit is due exactly one edge after the event, StreamID and settings it depends on. A write lands at the same edge that samples the event, so the written setting applies only to the following event.

The bench drives stimulus at falling edges. At each rising edge it evaluates its own model, using the settings held before any write in that cycle, and only afterwards applies that cycle's write to the model. It compares `qual` at the next falling edge, so every cycle is compared once, with the expected value for that edge.

// File: rtl/sid_span_filter.sv
module sid_span_filter #(
  parameter int NUM_CTR    = 4,
  parameter int NUM_CODES  = 8,
  parameter int CODE_W     = 16,
  parameter int SID_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int ETYPE_BASE = 'h400,
  parameter int PAT_BASE   = 'hA00,
  parameter int SPAN_BIT   = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glob_filt,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [NUM_CODES-1:0] ev_hit,
  input  logic [SID_W-1:0]     ev_sid,
  output logic [NUM_CTR-1:0]   qual
);
  localparam int CI_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;

  logic [NUM_CTR-1:0][CODE_W-1:0] code_q;
  logic [NUM_CTR-1:0]             span_q;
  logic [NUM_CTR-1:0][SID_W-1:0]  sid_q;
  logic [NUM_CTR-1:0]             qual_d;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [ADDR_W-1:0] ET_A  = ADDR_W'(ETYPE_BASE + 4 * i);
    localparam logic [ADDR_W-1:0] PAT_A = ADDR_W'(PAT_BASE + 4 * i);

    logic             sel_span, code_zero, code_ok, sid_ok;
    logic [SID_W-1:0] sel_sid, dc_mask;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[i] <= '0;
        span_q[i] <= 1'b1;
        sid_q[i]  <= '1;
      end else if (wr_en) begin
        if (wr_addr == ET_A) begin
          code_q[i] <= wr_data[CODE_W-1:0];
          span_q[i] <= wr_data[SPAN_BIT];
        end
        if (wr_addr == PAT_A) sid_q[i] <= wr_data[SID_W-1:0];
      end
    end

    assign sel_span  = glob_filt ? span_q[0] : span_q[i];
    assign sel_sid   = glob_filt ? sid_q[0]  : sid_q[i];
    assign dc_mask   = sel_span ? (sel_sid ^ (sel_sid + 1'b1)) : '0;
    assign sid_ok    = ((ev_sid ^ sel_sid) & ~dc_mask) == '0;
    assign code_zero = code_q[i] == '0;
    assign code_ok   = (code_q[i] < CODE_W'(NUM_CODES)) && ev_hit[code_q[i][CI_W-1:0]];
    assign qual_d[i] = code_zero | (code_ok & sid_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) qual <= '0;
    else        qual <= qual_d;
  end
endmodule

// File: rtl/sid_span_filter_chk.sv
module sid_span_filter_chk #(
  parameter int NUM_CTR    = 4,
  parameter int NUM_CODES  = 8,
  parameter int CODE_W     = 16,
  parameter int SID_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int ETYPE_BASE = 'h400,
  parameter int PAT_BASE   = 'hA00
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              wr_addr,
  input logic [NUM_CODES-1:0]           ev_hit,
  input logic [NUM_CTR-1:0]             qual,
  input logic [NUM_CTR-1:0][CODE_W-1:0] code_q,
  input logic [NUM_CTR-1:0]             span_q,
  input logic [NUM_CTR-1:0][SID_W-1:0]  sid_q
);
  logic [NUM_CTR-1:0] zc;
  logic               addr_miss;

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) zc[i] = (code_q[i] == '0);
  end

  assign addr_miss =
    !((int'(wr_addr) >= ETYPE_BASE) && (int'(wr_addr) < ETYPE_BASE + 4 * NUM_CTR)) &&
    !((int'(wr_addr) >= PAT_BASE)   && (int'(wr_addr) < PAT_BASE + 4 * NUM_CTR));

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> qual == '0);

  // R2
  cycles_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((qual & $past(zc)) == $past(zc)));

  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit == '0) |=> ((qual & ~$past(zc)) == '0));

  // R9
  decode_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_miss) |=> ($stable(code_q) && $stable(span_q) && $stable(sid_q)));
endmodule

bind sid_span_filter sid_span_filter_chk #(
  .NUM_CTR(NUM_CTR), .NUM_CODES(NUM_CODES), .CODE_W(CODE_W), .SID_W(SID_W),
  .ADDR_W(ADDR_W), .ETYPE_BASE(ETYPE_BASE), .PAT_BASE(PAT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ev_hit(ev_hit),
  .qual(qual), .code_q(code_q), .span_q(span_q), .sid_q(sid_q)
);

// File: tb/test_sid_span_filter.sv
`timescale 1ns/1ps
module test_sid_span_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glob_filt = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  ev_hit = '0;
  logic [31:0] ev_sid = '0;
  logic [3:0]  qual;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int          m_code [4];
  bit          m_span [4];
  logic [31:0] m_sid  [4];

  always #5 clk = ~clk;

  sid_span_filter i_sid_span_filter (
    .clk(clk), .rst_n(rst_n), .glob_filt(glob_filt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ev_hit(ev_hit), .ev_sid(ev_sid),
    .qual(qual)
  );

  function automatic bit sid_match(logic [31:0] pat, bit span, logic [31:0] sid);
    int  y;
    bit  found;
    if (!span) return pat == sid;
    y = 32;
    found = 0;
    for (int b = 0; b < 32; b++) begin
      if (!found && !pat[b]) begin
        y = b + 1;
        found = 1;
      end
    end
    for (int b = y; b < 32; b++) if (pat[b] != sid[b]) return 0;
    return 1;
  endfunction

  function automatic logic [3:0] model_qual();
    logic [3:0] q;
    for (int i = 0; i < 4; i++) begin
      int k = glob_filt ? 0 : i;
      if (m_code[i] == 0) q[i] = 1'b1;
      else if (m_code[i] >= 8) q[i] = 1'b0;
      else q[i] = ev_hit[m_code[i]] && sid_match(m_sid[k], m_span[k], ev_sid);
    end
    return q;
  endfunction

  task automatic model_write();
    int a = int'(wr_addr);
    if (!wr_en) return;
    if (a >= 'h400 && a < 'h410 && a % 4 == 0) begin
      m_code[(a - 'h400) / 4] = int'(wr_data[15:0]);
      m_span[(a - 'h400) / 4] = wr_data[29];
    end
    if (a >= 'hA00 && a < 'hA10 && a % 4 == 0) m_sid[(a - 'hA00) / 4] = wr_data;
  endtask

  task automatic step(string tag);
    logic [3:0] exp;
    @(posedge clk);
    if (!rst_n) begin
      exp = '0;
      for (int i = 0; i < 4; i++) begin
        m_code[i] = 0;
        m_span[i] = 1;
        m_sid[i]  = '1;
      end
    end else begin
      exp = model_qual();
      model_write();
    end
    @(negedge clk);
    compared++;
    if (qual !== exp) begin
      mismatched++;
      $display("FAIL %s: qual actual %b expected %b (sid %h hit %b glob %b)",
               tag, qual, exp, ev_sid, ev_hit, glob_filt);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  task automatic ev(logic [7:0] h, logic [31:0] s, string tag);
    ev_hit = h; ev_sid = s;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    ev_hit = 8'hFF;
    for (int i = 0; i < 3; i++) step("R1 reset");
    rst_n = 1;
    step("R1 defaults");
    // R2: all counters default to code 0
    ev(8'h00, 32'h1234, "R2 no strobe");
    ev(8'h5A, 32'hDEAD, "R2 mixed strobe");
    // R9: program counters
    wr(12'h404, 32'h0000_0003, "R9 etype1 exact");
    wr(12'hA04, 32'h0000_0055, "R9 pat1");
    wr(12'h408, 32'h2000_0003, "R9 etype2 span");
    wr(12'hA08, 32'h0000_0042, "R9 pat2");
    wr(12'h40C, 32'h2000_0005, "R9 etype3 span");
    wr(12'h400, 32'h2000_0003, "R9 etype0 span");
    wr(12'hA00, 32'h0000_0007, "R9 pat0");
    // R4
    ev(8'h08, 32'h0000_0055, "R4 exact hit");
    ev(8'h08, 32'h0000_0054, "R4 exact miss low");
    ev(8'h08, 32'h0000_0155, "R4 exact miss high");
    ev(8'h08, 32'h8000_0055, "R4 exact miss msb");
    // R5
    ev(8'h08, 32'h0000_0042, "R5 span 0x42");
    ev(8'h08, 32'h0000_0043, "R5 span 0x43");
    ev(8'h08, 32'h0000_0041, "R5 span 0x41 miss");
    ev(8'h08, 32'h0000_0040, "R5 span 0x40 miss");
    ev(8'h08, 32'h0000_000F, "R5 span 0x07 wide");
    ev(8'h08, 32'h0000_0010, "R5 span 0x07 miss");
    // R6
    ev(8'h20, 32'hFFFF_FFFF, "R6 all ones a");
    ev(8'h20, 32'h0000_0000, "R6 all ones b");
    ev(8'h20, 32'h7A5C_3E91, "R6 all ones c");
    // R3
    ev(8'hD7, 32'h0000_0042, "R3 other codes");
    ev(8'h00, 32'h0000_0042, "R3 no strobe");
    wr(12'h40C, 32'h2000_0009, "R3 code beyond");
    ev(8'hFF, 32'h0000_0000, "R3 code beyond range");
    wr(12'h40C, 32'h2000_0005, "R3 restore");
    // R9: decode misses must change nothing
    wr(12'h410, 32'h0000_0001, "R9 miss etype");
    wr(12'hA10, 32'h0000_0000, "R9 miss pat");
    wr(12'h402, 32'h0000_0000, "R9 miss unaligned");
    wr(12'h800, 32'h0000_0000, "R9 miss other");
    ev(8'h28, 32'h0000_0055, "R9 settings kept a");
    ev(8'h28, 32'h0000_0043, "R9 settings kept b");
    // R7
    glob_filt = 1;
    ev(8'h28, 32'h0000_0005, "R7 global pat0 match");
    ev(8'h28, 32'h0000_0055, "R7 global pat0 miss");
    ev(8'h28, 32'h0000_0042, "R7 global pat0 miss b");
    wr(12'h400, 32'h0000_0003, "R7 global exact");
    ev(8'h28, 32'h0000_0007, "R7 global exact hit");
    ev(8'h28, 32'h0000_0006, "R7 global exact miss");
    // R8
    glob_filt = 0;
    ev(8'h28, 32'h0000_0042, "R8 own filters");
    ev(8'h28, 32'h0000_0055, "R8 own filters b");
    // R10: write and event in the same cycle
    ev_hit = 8'h08; ev_sid = 32'h0000_0055;
    wr(12'hA04, 32'h0000_0066, "R10 old pattern applies");
    ev(8'h08, 32'h0000_0055, "R10 new pattern miss");
    ev(8'h08, 32'h0000_0066, "R10 new pattern hit");
    wr(12'h404, 32'h0000_0000, "R10 to cycles");
    ev(8'h00, 32'h0000_0000, "R10 R2 cycles after write");
    // mixed sweep
    for (int n = 0; n < 200; n++) begin
      glob_filt = n[5];
      ev_hit = 8'($urandom);
      ev_sid = {26'h0, 6'($urandom)} | 32'h40;
      if (n % 7 == 0) begin
        wr_en = 1;
        wr_addr = (n % 2 == 0) ? 12'h400 + 12'(4 * (n % 4)) : 12'hA00 + 12'(4 * (n % 4));
        wr_data = (n % 2 == 0) ? {2'b0, 1'($urandom), 26'h0, 3'($urandom)} : 32'h40 | 32'($urandom % 16);
      end
      step("R8 sweep");
      wr_en = 0;
    end
    // R1 again mid-run
    rst_n = 0;
    step("R1 reset again");
    rst_n = 1;
    step("R1 after reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule